// File: doc/BRIEF.md
# Late-Write Pipelined Single-Port Memory

This block is a clocked single-port word memory whose writes are split across two clock edges: a write command (address and lane enables) is taken on one rising edge and its data on the next. The write is not placed in the storage array at once. It waits in a one-entry holding register and is only copied into the array when the next write command arrives. Any number of reads may come in between. A read whose address equals the held write's address is served lane by lane. Lanes that the held write enabled come from the holding register. All other lanes come from the array.

Reads are registered on the rising edge and the result is presented for the whole following cycle. A data-valid flag tells the surrounding logic when the data bus carries a read result. An active-low output enable and a sleep input both force the bus undriven without waiting for a clock. Sleep also blocks new commands while the stored words are kept. A small controller with three states gates command acceptance:
- `ST_RUN` (commands accepted) moves to `ST_SLEEP` when sleep is high at an edge.
- `ST_SLEEP` moves to `ST_WAKE` on the first edge with sleep low.
- `ST_WAKE` moves back to `ST_SLEEP` if sleep rises again. It moves to `ST_RUN` after `WAKE_CYC` edges spent in the state.

Top module: `lw_sram`

## Requirements
- R1: Reset drives `rd_drv` low and `rd_data` to zero. Reset discards a write still held in the holding register, so that write never reaches the array.
- R2: A read command is `sel_n`=0 with `wr_n`=1, sampled on a rising edge. After that edge, `rd_drv` is high and `rd_data` shows the addressed word until the next rising edge.
- R3: A write command is `sel_n`=0 with `wr_n`=0. Its data is taken from `wr_data` on the rising edge that follows the command edge.
- R4: A held write is copied into the array only when the next accepted write command arrives. Reads in between do not copy it, and they return its enabled lanes from the holding register.
- R5: On an address match, lane i (bits 9i+8..9i) comes from the held write when that write had `lane_en_n[i]`=0. Otherwise lane i comes from the array.
- R6: A read taken on the same edge that captures the held write's data already returns that data.
- R7: For two write commands on consecutive edges, the first write is copied into the array using the data that arrives on the second command's edge.
- R8: A write command with `lane_en_n`=4'hF changes no stored lane, either by bypass or after it is copied into the array.
- R9: After an edge where `sel_n` was 1 or `wr_n` was 0, `rd_drv` is low and `rd_data` is zero for the following cycle.
- R10: `oe_n`=1 forces `rd_drv` low and `rd_data` to zero at once, without waiting for a clock edge.
- R11: `sleep`=1 forces the bus undriven at once, and commands seen at edges while it is high are ignored. Stored words are kept.
- R12: After `sleep` falls, commands are ignored on the first `WAKE_CYC`+1 rising edges. They are accepted from the next edge on.
- R13: Back-to-back reads of one address keep `rd_data` unchanged across the edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Command address |
| sel_n | input | 1 | Active-low command select |
| wr_n | input | 1 | Low for write, high for read |
| lane_en_n | input | LANES | Active-low per-lane write enables |
| wr_data | input | LANES*LANE_W | Write data, one edge after its command |
| oe_n | input | 1 | Active-low output enable, combinational |
| sleep | input | 1 | Low-power request, blocks commands |
| rd_data | output | LANES*LANE_W | Read data, zero when not driven |
| rd_drv | output | 1 | High when `rd_data` carries a read result |

## Verification
The bench first targets ordering hazards around the holding register:
- A read landing on the same edge as the held data's arrival. A design that compares against the old register contents returns stale data there.
- Two writes on adjacent edges. Committing from the register instead of the incoming bus stores the previous contents.
- A partial-lane write followed by a read of the same address. A whole-word bypass would zero the untouched lanes.

It also resets the block with a write still held and then reads that address. An eager design would show the discarded data.

The wake window is checked edge by edge. An off-by-one counter would accept a command one edge early or late.

// File: rtl/lw_pkg.sv
package lw_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } lw_state_e;

endpackage

// File: rtl/lw_ctrl.sv
module lw_ctrl
    import lw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WAKE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_acc,
    output logic              rd_vld_q,
    output logic [ADDR_W-1:0] rd_addr_q
);

    localparam int CNT_W = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

    lw_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             live, rd_acc;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep) state_d = ST_SLEEP;
            ST_SLEEP: if (!sleep) state_d = ST_WAKE;
            ST_WAKE: begin
                if (sleep)                  state_d = ST_SLEEP;
                else if (cnt_q == CNT_LAST) state_d = ST_RUN;
            end
            default:  state_d = ST_RUN;
        endcase
    end

    // State register and wake counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAKE && state_d == ST_WAKE)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // Command acceptance outputs
    always_comb begin
        live   = (state_q == ST_RUN) && !sleep;
        wr_acc = live && !sel_n && !wr_n;
        rd_acc = live && !sel_n && wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_vld_q <= rd_acc;
            if (rd_acc) rd_addr_q <= addr;
        end
    end

    // R12: the run state is only ever entered from the wake state
    a_r12_run_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_WAKE);

    // R11: sleep sampled at an edge leaves no read pending
    a_r11_sleep_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rd_vld_q);

endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hold_vld,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [LANES-1:0]  hold_en,
    output logic [DATA_W-1:0] hold_data,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [LANES-1:0]  cm_en,
    output logic [DATA_W-1:0] cm_data
);

    logic data_due;

    // Commit the held write when a new write command is accepted
    always_comb begin
        cm_we   = wr_acc && hold_vld;
        cm_addr = hold_addr;
        cm_en   = hold_en;
        cm_data = data_due ? wr_data : hold_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_addr <= '0;
            hold_en   <= '0;
            data_due  <= 1'b0;
        end else if (wr_acc) begin
            hold_vld  <= 1'b1;
            hold_addr <= addr;
            hold_en   <= lane_en;
            data_due  <= 1'b1;
        end else if (data_due) begin
            data_due  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_data <= '0;
        else if (data_due) hold_data <= wr_data;
    end

    // R3: a data phase lasts exactly one edge unless a new write follows
    a_r3_data_phase_once: assert property (@(posedge clk) disable iff (!rst_n)
        (data_due && !wr_acc) |=> !data_due);

    // R1: after reset nothing is held until a write is accepted
    a_r1_hold_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_vld && !wr_acc) |=> !hold_vld);

endmodule

// File: rtl/lw_array.sv
module lw_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wen[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_bypass.sv
module lw_bypass #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_word,
    input  logic              hold_vld,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [LANES-1:0]  hold_en,
    input  logic [DATA_W-1:0] hold_data,
    output logic [DATA_W-1:0] word
);

    logic hit;

    assign hit = hold_vld && (hold_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_mux
        assign word[l*LANE_W +: LANE_W] = (hit && hold_en[l])
            ? hold_data[l*LANE_W +: LANE_W]
            : arr_word[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int WAKE_CYC = 3,
    localparam int DATA_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drv
);

    logic              wr_acc, rd_vld_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              hold_vld;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANES-1:0]  hold_en;
    logic [DATA_W-1:0] hold_data;
    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_en;
    logic [DATA_W-1:0] cm_data;
    logic [DATA_W-1:0] arr_word, merged;

    lw_ctrl #(.ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
        .addr(addr), .wr_acc(wr_acc), .rd_vld_q(rd_vld_q), .rd_addr_q(rd_addr_q)
    );

    lw_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) wbuf_i (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .addr(addr),
        .lane_en(~lane_en_n), .wr_data(wr_data),
        .hold_vld(hold_vld), .hold_addr(hold_addr), .hold_en(hold_en),
        .hold_data(hold_data), .cm_we(cm_we), .cm_addr(cm_addr),
        .cm_en(cm_en), .cm_data(cm_data)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .we(cm_we), .waddr(cm_addr), .wen(cm_en), .wdata(cm_data),
        .raddr(rd_addr_q), .rdata(arr_word)
    );

    lw_bypass #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) bypass_i (
        .rd_addr(rd_addr_q), .arr_word(arr_word), .hold_vld(hold_vld),
        .hold_addr(hold_addr), .hold_en(hold_en), .hold_data(hold_data),
        .word(merged)
    );

    always_comb begin
        rd_drv  = rd_vld_q && !oe_n && !sleep;
        rd_data = rd_drv ? merged : '0;
    end

    // R9: only a read command at the previous edge can make the bus driven
    a_r9_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!sel_n && wr_n) |-> !rd_drv);

    // R11: sleep at the previous edge leaves the bus undriven
    a_r11_sleep_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> !rd_drv);

    // R4: the array is only written on an edge carrying a write command
    a_r4_commit_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> (!sel_n && !wr_n && !sleep));

    // R10: bus value is zero whenever it is not driven
    a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drv |-> (rd_data == '0));

endmodule

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;

    localparam int AW = 6;
    localparam int DW = 36;
    localparam int WK = 3;

    localparam logic [DW-1:0] D5  = 36'h1_2345_6789;
    localparam logic [DW-1:0] DFF = 36'hF_FFFF_FFFF;
    localparam logic [DW-1:0] DMX = 36'hF_F803_FE00;
    localparam logic [DW-1:0] DF0 = 36'h0_F0F0_F0F0;

    typedef struct packed {
        logic          sel_n;
        logic          wr_n;
        logic [3:0]    ben_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          exp_drv;
        logic [DW-1:0] exp_data;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 4'h0, 6'h05, 36'h0,           1'b0, 36'h0, 8'd9},  // R9 write cmd
        '{1'b0, 1'b0, 4'h0, 6'h09, D5,              1'b0, 36'h0, 8'd3},  // R3 data of 05
        '{1'b0, 1'b1, 4'hF, 6'h05, DFF,             1'b1, D5,    8'd7},  // R7 R2
        '{1'b0, 1'b1, 4'hF, 6'h09, 36'h0,           1'b1, DFF,   8'd4},  // R4 bypass
        '{1'b0, 1'b1, 4'hF, 6'h09, 36'h0,           1'b1, DFF,   8'd13}, // R13
        '{1'b1, 1'b1, 4'hF, 6'h00, 36'h0,           1'b0, 36'h0, 8'd9},  // R9 deselect
        '{1'b0, 1'b0, 4'hA, 6'h09, 36'h0,           1'b0, 36'h0, 8'd9},  // R9 lanes 0,2
        '{1'b0, 1'b1, 4'hF, 6'h09, 36'h0,           1'b1, DMX,   8'd5},  // R5 merge
        '{1'b0, 1'b0, 4'hF, 6'h05, 36'h0,           1'b0, 36'h0, 8'd8},  // R8 null write
        '{1'b0, 1'b1, 4'hF, 6'h05, 36'h1_1111_1111, 1'b1, D5,    8'd8},  // R8 no bypass
        '{1'b0, 1'b1, 4'hF, 6'h09, 36'h0,           1'b1, DMX,   8'd4},  // R4 committed
        '{1'b0, 1'b0, 4'h0, 6'h21, 36'h0,           1'b0, 36'h0, 8'd8},  // R8 commit null
        '{1'b0, 1'b1, 4'hF, 6'h21, DF0,             1'b1, DF0,   8'd6},  // R6 same edge
        '{1'b0, 1'b1, 4'hF, 6'h05, 36'h0,           1'b1, D5,    8'd8}   // R8 unchanged
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          sel_n, wr_n, oe_n, sleep;
    logic [3:0]    lane_en_n;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_drv;
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9), .WAKE_CYC(WK)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
        .lane_en_n(lane_en_n), .wr_data(wr_data), .oe_n(oe_n), .sleep(sleep),
        .rd_data(rd_data), .rd_drv(rd_drv)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [3:0] b,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel_n = s; wr_n = w; lane_en_n = b; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; lane_en_n = 4'hF;
        addr = '0; wr_data = '0; oe_n = 1'b0; sleep = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 drv", {35'b0, rd_drv}, 36'h0);
        chk("R1 data", rd_data, 36'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].sel_n, TBL[i].wr_n, TBL[i].ben_n, TBL[i].addr, TBL[i].wdata);
            chk($sformatf("R%0d drv row %0d", TBL[i].req, i), {35'b0, rd_drv}, {35'b0, TBL[i].exp_drv});
            chk($sformatf("R%0d data row %0d", TBL[i].req, i), rd_data, TBL[i].exp_data);
        end

        // R13: same-address reads stay constant across the edge
        cyc(1'b0, 1'b1, 4'hF, 6'h21, '0);
        sel_n = 1'b0; wr_n = 1'b1; addr = 6'h21;
        @(posedge clk);
        #1 chk("R13 just after edge", rd_data, DF0);
        @(negedge clk);
        chk("R13 mid cycle", rd_data, DF0);

        // R10: output enable acts without a clock
        cyc(1'b0, 1'b1, 4'hF, 6'h05, '0);
        chk("R2 read", rd_data, D5);
        oe_n = 1'b1;
        #1 chk("R10 drv off", {35'b0, rd_drv}, 36'h0);
        chk("R10 data zero", rd_data, 36'h0);
        oe_n = 1'b0;
        #1 chk("R10 drv back", {35'b0, rd_drv}, 36'h1);

        // R4 / R1: held write survives reads, is lost on reset
        cyc(1'b0, 1'b0, 4'h0, 6'h05, '0);
        cyc(1'b1, 1'b1, 4'hF, 6'h00, 36'h1);
        cyc(1'b0, 1'b1, 4'hF, 6'h05, '0);
        chk("R4 held bypass", rd_data, 36'h1);
        cyc(1'b0, 1'b1, 4'hF, 6'h09, '0);
        chk("R4 other addr", rd_data, DMX);
        rst_n = 1'b0;
        #1 chk("R1 reset drv", {35'b0, rd_drv}, 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 4'hF, 6'h05, '0);
        chk("R1 held write discarded", rd_data, D5);

        // R11: sleep is immediate and blocks commands
        sleep = 1'b1;
        #1 chk("R11 immediate undriven", {35'b0, rd_drv}, 36'h0);
        cyc(1'b0, 1'b0, 4'h0, 6'h05, '0);
        cyc(1'b1, 1'b1, 4'hF, 6'h00, 36'h7);
        cyc(1'b0, 1'b1, 4'hF, 6'h05, '0);
        chk("R11 read ignored", {35'b0, rd_drv}, 36'h0);

        // R12: wake window of WK+1 ignored edges
        sleep = 1'b0;
        for (int k = 0; k <= WK; k++) begin
            cyc(1'b0, 1'b1, 4'hF, 6'h05, '0);
            chk($sformatf("R12 ignored edge %0d", k), {35'b0, rd_drv}, 36'h0);
        end
        cyc(1'b0, 1'b1, 4'hF, 6'h05, '0);
        chk("R12 accepted drv", {35'b0, rd_drv}, 36'h1);
        chk("R11 contents kept", rd_data, D5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule